// File: doc/BRIEF.md
# Bus Address Zone Decoder with Programmable Wait States

This block sits on the processor side of a 24-bit memory bus. It decodes every access into one of five zones: boot ROM, static RAM, dynamic RAM, peripheral I/O and the on-chip register bank. It also holds the processor in wait for a number of cycles that software sets for each external zone. An access starts with a one-cycle address strobe. The block latches the zone and the transfer attributes, drives the matching zone select and holds the wait line for the programmed count. It then gives one completion cycle, in which write strobes for the even and odd byte lanes of the 16-bit memory are issued.

The lowest 4 MB can be mapped either to ROM or to DRAM by an input bit. With that bit low, the ROM alias at address zero serves the boot fetch and the window above it is unmapped. A power-save input removes all wait states, because at a slow clock every device answers in time.

Top module: `bus_zone_ctrl`

## Requirements
- R1: Addresses 0x000000 to 0x3FFFFF select ROM when `low_dram` is 0 and select DRAM when `low_dram` is 1.
- R2: 0x800000 to 0xBFFFFF selects ROM, 0xC00000 to 0xDFFFFF selects SRAM, 0xE00000 to 0xEFFFFF selects I/O, and 0xF00000 to 0xFFFFFF selects the register bank, for either value of `low_dram`.
- R3: 0x400000 to 0x7FFFFF selects DRAM when `low_dram` is 1. When `low_dram` is 0 it asserts no zone select, raises `map_err` for the length of the access and completes with zero waits.
- R4: The wait count comes from `wait_cfg` as a 3-bit field per zone: ROM bits 2:0, SRAM bits 5:3, DRAM bits 8:6, I/O bits 11:9. `bus_wait` is high for exactly that many cycles, starting in the cycle after the strobe edge. One completion cycle with `bus_wait` low then follows.
- R5: Accesses to the register bank always complete with zero waits: the completion cycle directly follows the strobe edge.
- R6: When `power_save` is 1 at the strobe edge, the access completes with zero waits whatever the programmed counts.
- R7: Reset sets every wait field to 7, so `wait_cfg` reads 0xFFF.
- R8: In the completion cycle of a write (`wr` = 1), `we_even` equals `byte_en[0]` and `we_odd` equals `byte_en[1]`. Reads are full words and never assert either strobe.
- R9: Zone selects and `map_err` are held from the cycle after the strobe edge through the completion cycle. At most one select is high at a time, and all of them are low when no access is in progress.
- R10: An address strobe that arrives while an access is in progress is ignored. The running access keeps its zone and count, and no further access follows it.
- R11: `cfg_we` loads `cfg_wdata` into `wait_cfg` at the clock edge, and the new counts apply to the next access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_strobe | input | 1 | One-cycle start of an access |
| addr | input | 24 | Byte address |
| wr | input | 1 | 1 = write, 0 = read |
| byte_en | input | 2 | Bit 0 even byte, bit 1 odd byte |
| low_dram | input | 1 | Maps the lowest 4 MB to DRAM when 1 |
| power_save | input | 1 | Forces zero wait states |
| cfg_we | input | 1 | Load enable for the wait configuration |
| cfg_wdata | input | 12 | New wait configuration |
| wait_cfg | output | 12 | Current wait configuration |
| sel_rom | output | 1 | ROM zone select |
| sel_sram | output | 1 | SRAM zone select |
| sel_dram | output | 1 | DRAM zone select |
| sel_io | output | 1 | I/O zone select |
| sel_regs | output | 1 | Register bank select |
| map_err | output | 1 | Unmapped access in progress |
| bus_wait | output | 1 | Processor wait request |
| we_even | output | 1 | Even byte write strobe |
| we_odd | output | 1 | Odd byte write strobe |

## Verification
On every cycle the assertions check three things. The wait run ends in a completion cycle whose length matches the count latched at the strobe. Power-save and register-bank accesses never wait. The selects stay one-hot or zero, stay clear during an error, and hold steady for the whole access. Only the bench's sweeps can show that each address boundary lands in the right zone for both mappings, that each configuration field reaches its own zone, and that byte strobes follow the lane enables. The same holds for the reset counts, for the timing of a configuration change, and for a stray strobe dropped during a long wait.

// File: rtl/bzc_pkg.sv
package bzc_pkg;
  typedef enum logic [2:0] {
    ZN_ROM  = 3'd0,
    ZN_SRAM = 3'd1,
    ZN_DRAM = 3'd2,
    ZN_IO   = 3'd3,
    ZN_REGS = 3'd4,
    ZN_NONE = 3'd5
  } zone_e;

  // Decode from the top nibble of the address.
  function automatic zone_e zone_of(input logic [3:0] nib, input logic low_dram);
    zone_e z;
    unique casez (nib)
      4'b00??: z = low_dram ? ZN_DRAM : ZN_ROM;
      4'b01??: z = low_dram ? ZN_DRAM : ZN_NONE;
      4'b10??: z = ZN_ROM;
      4'b110?: z = ZN_SRAM;
      4'b1110: z = ZN_IO;
      default: z = ZN_REGS;
    endcase
    return z;
  endfunction

  function automatic logic zone_waits(input zone_e z);
    return (z == ZN_ROM) || (z == ZN_SRAM) || (z == ZN_DRAM) || (z == ZN_IO);
  endfunction
endpackage

// File: rtl/bzc_zone_decode.sv
module bzc_zone_decode
  import bzc_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              low_dram,
  output zone_e             zone
);
  localparam int TOP = ADDR_W - 1;
  always_comb zone = zone_of(addr[TOP -: 4], low_dram);
endmodule

// File: rtl/bzc_wait_cfg.sv
module bzc_wait_cfg #(
  parameter int CNT_W = 3,
  parameter int NZ    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [NZ*CNT_W-1:0] wdata,
  output logic [NZ*CNT_W-1:0] cfg
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg <= '1;
    else if (we) cfg <= wdata;
  end

  AST_RESET_MAX: assert property (@(posedge clk) $rose(rst_n) |-> cfg == '1); // R7
endmodule

// File: rtl/bzc_wait_seq.sv
module bzc_wait_seq #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic [CNT_W-1:0] load_cnt,
  output logic             accept,
  output logic             busy,
  output logic             bus_wait,
  output logic             done
);
  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_DONE} st_e;
  st_e              st;
  logic [CNT_W-1:0] rem;

  assign accept   = start_req && (st == S_IDLE);
  assign busy     = (st != S_IDLE);
  assign bus_wait = (st == S_WAIT);
  assign done     = (st == S_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      rem <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (start_req) begin
          rem <= load_cnt;
          st  <= (load_cnt != '0) ? S_WAIT : S_DONE;
        end
        S_WAIT: begin
          rem <= rem - 1'b1;
          if (rem == CNT_W'(1)) st <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // Checker: count wait cycles and compare with the count taken at accept.
  logic [CNT_W:0]   run_cnt;
  logic [CNT_W-1:0] lat_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
      lat_cnt <= '0;
    end else if (accept) begin
      run_cnt <= '0;
      lat_cnt <= load_cnt;
    end else if (bus_wait) begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  AST_WAIT_LEN:   assert property (@(posedge clk) disable iff (!rst_n) done |-> run_cnt == {1'b0, lat_cnt}); // R4
  AST_WAIT_ENDS:  assert property (@(posedge clk) disable iff (!rst_n) $fell(bus_wait) |-> done); // R4
  AST_ZERO_DIRECT: assert property (@(posedge clk) disable iff (!rst_n) (accept && load_cnt == '0) |=> done); // R5
  AST_DONE_ONCE:  assert property (@(posedge clk) disable iff (!rst_n) done |=> !busy); // R10
endmodule

// File: rtl/bus_zone_ctrl.sv
module bus_zone_ctrl
  import bzc_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 3,
  parameter int NZ     = 4,
  parameter int CFG_W  = NZ * CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_strobe,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [1:0]        byte_en,
  input  logic              low_dram,
  input  logic              power_save,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  wait_cfg,
  output logic              sel_rom,
  output logic              sel_sram,
  output logic              sel_dram,
  output logic              sel_io,
  output logic              sel_regs,
  output logic              map_err,
  output logic              bus_wait,
  output logic              we_even,
  output logic              we_odd
);
  localparam int ZI_W = $clog2(NZ);

  zone_e            zone_d, zone_q;
  logic             wr_q;
  logic [1:0]       be_q;
  logic [CNT_W-1:0] cnt_of [NZ];
  logic [CNT_W-1:0] load_cnt;
  logic             accept, busy, done;
  logic             zero_wait;

  bzc_zone_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(addr), .low_dram(low_dram), .zone(zone_d)
  );

  bzc_wait_cfg #(.CNT_W(CNT_W), .NZ(NZ)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata), .cfg(wait_cfg)
  );

  for (genvar z = 0; z < NZ; z++) begin : g_field
    assign cnt_of[z] = wait_cfg[z*CNT_W +: CNT_W];
  end

  assign zero_wait = power_save || !zone_waits(zone_d);
  assign load_cnt  = zero_wait ? '0 : cnt_of[zone_d[ZI_W-1:0]];

  bzc_wait_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_req(addr_strobe), .load_cnt(load_cnt),
    .accept(accept), .busy(busy), .bus_wait(bus_wait), .done(done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zone_q <= ZN_NONE;
      wr_q   <= 1'b0;
      be_q   <= '0;
    end else if (accept) begin
      zone_q <= zone_d;
      wr_q   <= wr;
      be_q   <= byte_en;
    end
  end

  assign sel_rom  = busy && (zone_q == ZN_ROM);
  assign sel_sram = busy && (zone_q == ZN_SRAM);
  assign sel_dram = busy && (zone_q == ZN_DRAM);
  assign sel_io   = busy && (zone_q == ZN_IO);
  assign sel_regs = busy && (zone_q == ZN_REGS);
  assign map_err  = busy && (zone_q == ZN_NONE);
  assign we_even  = done && wr_q && be_q[0];
  assign we_odd   = done && wr_q && be_q[1];

  logic [4:0] sel_vec;
  assign sel_vec = {sel_regs, sel_io, sel_dram, sel_sram, sel_rom};

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(sel_vec)); // R9
  AST_ERR_NOSEL:  assert property (@(posedge clk) disable iff (!rst_n) map_err |-> sel_vec == '0); // R3
  AST_STROBE_END: assert property (@(posedge clk) disable iff (!rst_n) (we_even || we_odd) |-> (!bus_wait && busy)); // R8
  AST_PS_NOWAIT:  assert property (@(posedge clk) disable iff (!rst_n) (accept && power_save) |=> !bus_wait); // R6
  AST_REGS_NOWAIT: assert property (@(posedge clk) disable iff (!rst_n) (accept && zone_d == ZN_REGS) |=> !bus_wait); // R5
  AST_SEL_HOLD:   assert property (@(posedge clk) disable iff (!rst_n) (busy && !done) |=> ($stable(sel_vec) && $stable(map_err))); // R10
endmodule

// File: tb/bus_zone_ctrl_bench.sv
module bus_zone_ctrl_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        addr_strobe = 0;
  logic [23:0] addr = '0;
  logic        wr = 0;
  logic [1:0]  byte_en = '0;
  logic        low_dram = 0;
  logic        power_save = 0;
  logic        cfg_we = 0;
  logic [11:0] cfg_wdata = '0;
  logic [11:0] wait_cfg;
  logic sel_rom, sel_sram, sel_dram, sel_io, sel_regs, map_err, bus_wait, we_even, we_odd;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [11:0] cfg_model = 12'hFFF;

  bus_zone_ctrl u_bus_zone_ctrl (
    .clk(clk), .rst_n(rst_n), .addr_strobe(addr_strobe), .addr(addr), .wr(wr),
    .byte_en(byte_en), .low_dram(low_dram), .power_save(power_save),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .wait_cfg(wait_cfg),
    .sel_rom(sel_rom), .sel_sram(sel_sram), .sel_dram(sel_dram), .sel_io(sel_io),
    .sel_regs(sel_regs), .map_err(map_err), .bus_wait(bus_wait),
    .we_even(we_even), .we_odd(we_odd)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // 0 rom, 1 sram, 2 dram, 3 io, 4 regs, 5 unmapped
  function automatic int exp_zone(input logic [23:0] a, input logic low);
    if (a < 24'h400000) return low ? 2 : 0;
    if (a < 24'h800000) return low ? 2 : 5;
    if (a < 24'hC00000) return 0;
    if (a < 24'hE00000) return 1;
    if (a < 24'hF00000) return 3;
    return 4;
  endfunction

  function automatic int exp_waits(input int z, input logic ps);
    if (ps || z > 3) return 0;
    return int'((cfg_model >> (3 * z)) & 12'h7);
  endfunction

  function automatic int sel_code();
    return {27'd0, sel_regs, sel_io, sel_dram, sel_sram, sel_rom};
  endfunction

  task automatic access(input logic [23:0] a, input logic low, input logic ps,
                        input logic w, input logic [1:0] be, input string req);
    int z, n, seen;
    z = exp_zone(a, low);
    n = exp_waits(z, ps);
    addr = a; low_dram = low; power_save = ps; wr = w; byte_en = be;
    addr_strobe = 1;
    @(negedge clk);
    addr_strobe = 0;
    seen = 0;
    while (bus_wait && seen < 20) begin
      chk({req, " R9 select held"}, sel_code(), (z == 5) ? 0 : (1 << z));
      seen++;
      @(negedge clk);
    end
    chk({req, " R4 wait cycles"}, seen, n);
    chk({req, " R1 R2 zone select"}, sel_code(), (z == 5) ? 0 : (1 << z));
    chk({req, " R3 map_err"}, int'(map_err), int'(z == 5));
    chk({req, " R8 we_even"}, int'(we_even), int'(w & be[0]));
    chk({req, " R8 we_odd"}, int'(we_odd), int'(w & be[1]));
    @(negedge clk);
    chk({req, " R9 idle"}, sel_code() + int'(map_err) + int'(bus_wait), 0);
  endtask

  task automatic load_cfg(input logic [11:0] v);
    cfg_wdata = v; cfg_we = 1;
    @(negedge clk);
    cfg_we = 0;
    cfg_model = v;
    chk("R11 cfg load", int'(wait_cfg), int'(v));
  endtask

  logic [23:0] pts [16] = '{24'h000000, 24'h3FFFFF, 24'h400000, 24'h7FFFFF,
                            24'h800000, 24'hBFFFFE, 24'hC00000, 24'hDFFFFF,
                            24'hE00000, 24'hEFFFFF, 24'hF00000, 24'hFFFFFF,
                            24'h123456, 24'h5A5A5A, 24'hCAFE00, 24'hE80001};

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset selects", sel_code() + int'(map_err) + int'(bus_wait), 0);
    chk("R8 reset strobes", int'(we_even) + int'(we_odd), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R7 reset counts", int'(wait_cfg), 12'hFFF);
    access(24'h000000, 1'b0, 1'b0, 1'b0, 2'b11, "R7 boot fetch rom");

    for (int c = 0; c < 4; c++) begin
      if (c == 1) load_cfg(12'b011_010_001_000);
      if (c == 2) load_cfg(12'b000_101_111_100);
      if (c == 3) load_cfg(12'b110_001_000_111);
      for (int p = 0; p < 16; p++)
        for (int m = 0; m < 4; m++)
          access(pts[p], m[0], m[1], p[0], 2'(p + m), "sweep R5 R6");
    end

    // R10: stray strobe during a long wait is ignored
    load_cfg(12'b000_000_000_101);
    addr = 24'h800010; low_dram = 0; power_save = 0; wr = 1; byte_en = 2'b01;
    addr_strobe = 1;
    @(negedge clk);
    addr_strobe = 0;
    @(negedge clk);
    addr = 24'hF00000; wr = 0; addr_strobe = 1;
    @(negedge clk);
    addr_strobe = 0;
    begin
      int seen = 2;
      while (bus_wait && seen < 20) begin seen++; @(negedge clk); end
      chk("R10 running count kept", seen, 5);
    end
    chk("R10 zone kept", sel_code(), 1);
    chk("R10 write kept", int'(we_even), 1);
    @(negedge clk);
    chk("R10 no second access", sel_code() + int'(bus_wait), 0);
    @(negedge clk);
    chk("R10 still idle", sel_code() + int'(bus_wait), 0);

    // R11: new counts take effect on the next access
    load_cfg(12'b001_000_011_000);
    access(24'hC00100, 1'b0, 1'b0, 1'b1, 2'b10, "R11 sram after load");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule